// File: doc/BRIEF.md
# Edge and Level Interrupt Controller Bank

This block collects up to 64 interrupt sources into one request line for a processor. Sources are grouped in banks of 32. Each bank has four word registers on a small memory-mapped bus: the latched event flags, the enable mask, an acknowledge register that is written to clear flags, and a live view of the synchronized inputs. Bit n of each register belongs to source n of that bank.

Each source is either edge-type or level-type. In bank 0 a variant parameter picks which bits are level-type. An edge-type source is latched into its event flag when a rising edge arrives while the source is enabled. A level-type source counts as pending for as long as its input is high. Setting an enable bit while the input of an edge-type source is already high does not flag it, so software must read the level register to find such a source. A slave controller's request can be merged into one ordinary source of bank 0 through the cascade input.

The block registers two outputs. The processor request is the OR of all pending, enabled sources. The priority output gives the highest-numbered pending source across all banks.

Top module: `intc_edge_level`

## Requirements
- R1: After reset every enable bit and every event flag is 0, and cpu_irq and prio_valid are low.
- R2: A bus write to a bank's ack register (bank offset 0x8) clears each event flag whose bit in the written word is 1. Flags whose bit is 0 are left unchanged.
- R3: In bank 0, VARIANT 0 makes bits 20 to 29 level-type and VARIANT 1 makes bits 20 to 28 level-type. A level-type source never sets its event flag. It is pending while its synchronized input is high and it is enabled, and it stops being pending when the input falls, with no ack needed.
- R4: An enabled edge-type source sets its event flag on a rising edge of its input. The flag stays set after the input falls, until it is acked.
- R5: Enabling an edge-type source whose input is already high sets no event flag and raises no request. A later fresh rising edge while the source is enabled does set the flag.
- R6: The register window is addressed as bank*0x10 + sel*4, where sel 0 is event, 1 is enable, 2 is ack and 3 is level. Enable reads back exactly the last value written. Level reads the synchronized inputs. Ack reads as 0.
- R7: cpu_irq is a register holding the OR of (event | level & level_mask) & enable over all banks. It rises three clock edges after a level-type input rises: two edges for the synchronizer and one for the output register. It falls once nothing is pending.
- R8: prio_idx gives the highest-numbered pending source, counted as bank*32 + bit, and prio_valid is high exactly when some source is pending.
- R9: With NUM_BANKS = 2, sources 32 to 63 use the bank 1 registers at 0x10 to 0x1C, and all of them are edge-type.
- R10: casc_in is ORed into source CASCADE_SRC (default 24, which is level-type) before the synchronizer, so a slave request appears as that single source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte address within the 0x40 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | NUM_BANKS*32 | Raw, asynchronous source inputs |
| casc_in | input | 1 | Request from a cascaded slave controller |
| cpu_irq | output | 1 | Combined request to the processor |
| prio_valid | output | 1 | Some source is pending |
| prio_idx | output | clog2(NUM_BANKS*32) | Highest-numbered pending source |

## Verification
The tests use a single edge source, two edge sources acked one at a time, and an edge source that is already high when it is enabled. Together these separate correct edge latching from sampling the input level, and selective acks from clearing the whole bank. A level-type source is then raised and dropped, and bit 29 is compared between a wide and a narrow variant instance, which shows whether the mask variant is decoded. Sources pending at once in both banks, and the cascade input, test that the highest-numbered source wins across banks and that the slave request is merged into its chosen source.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int SRC_PER_BANK = 32;

   typedef enum logic [1:0] {
      SEL_EVENT  = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_ACK    = 2'd2,
      SEL_LEVEL  = 2'd3
   } reg_sel_e;

   // level-type source mask of one bank for a given variant
   function automatic logic [SRC_PER_BANK-1:0] level_mask_f(input int variant, input int bank);
      if (bank != 0) return '0;
      return (variant == 0) ? 32'h3FF0_0000 : 32'h1FF0_0000;
   endfunction

endpackage

// File: rtl/intc_sync_edge.sv
module intc_sync_edge #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] sync_q,
   output logic [WIDTH-1:0] rise
);

   initial begin
      assert (STAGES >= 2) else $error("intc_sync_edge: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         prev_q <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         prev_q <= stg[STAGES-1];
      end
   end

   assign sync_q = stg[STAGES-1];
   assign rise   = stg[STAGES-1] & ~prev_q;

endmodule

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter logic [SRC_PER_BANK-1:0] LMASK = '0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_hit,
   input  reg_sel_e                wr_sel,
   input  logic [SRC_PER_BANK-1:0] wdata,
   input  logic [SRC_PER_BANK-1:0] sync_in,
   input  logic [SRC_PER_BANK-1:0] rise,
   output logic [SRC_PER_BANK-1:0] event_q,
   output logic [SRC_PER_BANK-1:0] enable_q,
   output logic [SRC_PER_BANK-1:0] pending
);

   logic [SRC_PER_BANK-1:0] event_nxt;

   always_comb begin
      event_nxt = event_q;
      if (wr_hit && wr_sel == SEL_ACK) event_nxt = event_nxt & ~wdata;
      // a new edge wins over an ack in the same cycle
      event_nxt = event_nxt | (rise & enable_q & ~LMASK);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         event_q  <= '0;
         enable_q <= '0;
      end else begin
         event_q <= event_nxt;
         if (wr_hit && wr_sel == SEL_ENABLE) enable_q <= wdata;
      end
   end

   assign pending = (event_q | (sync_in & LMASK)) & enable_q;

endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
   parameter int WIDTH = 64,
   parameter int IW    = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] pend,
   output logic             any,
   output logic [IW-1:0]    idx
);

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (pend[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/intc_edge_level.sv
module intc_edge_level
   import intc_pkg::*;
#(
   parameter int NUM_BANKS   = 2,
   parameter int VARIANT     = 0,
   parameter int SYNC_STAGES = 2,
   parameter int CASCADE_EN  = 1,
   parameter int CASCADE_SRC = 24
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               bus_we,
   input  logic [5:0]                         bus_addr,
   input  logic [31:0]                        bus_wdata,
   output logic [31:0]                        bus_rdata,
   input  logic [NUM_BANKS*SRC_PER_BANK-1:0]  src_in,
   input  logic                               casc_in,
   output logic                               cpu_irq,
   output logic                               prio_valid,
   output logic [$clog2(NUM_BANKS*SRC_PER_BANK)-1:0] prio_idx
);

   localparam int NSRC  = NUM_BANKS * SRC_PER_BANK;
   localparam int IDX_W = $clog2(NSRC);
   localparam logic [SRC_PER_BANK-1:0] LMASK0 = level_mask_f(VARIANT, 0);

   initial begin
      assert (NUM_BANKS >= 1 && NUM_BANKS <= 2) else $error("NUM_BANKS must be 1 or 2");
      assert (VARIANT == 0 || VARIANT == 1) else $error("VARIANT must be 0 or 1");
      assert (CASCADE_SRC >= 0 && CASCADE_SRC < NSRC) else $error("CASCADE_SRC out of range");
   end

   logic [NSRC-1:0] src_eff;
   logic [NSRC-1:0] sync_flat;
   logic [NSRC-1:0] rise_flat;
   logic [NSRC-1:0] ev_flat;
   logic [NSRC-1:0] en_flat;
   logic [NSRC-1:0] pend_flat;
   logic            casc_bit;
   logic            any_pend;
   logic [IDX_W-1:0] top_idx;
   reg_sel_e        sel;

   assign casc_bit = (CASCADE_EN != 0) ? casc_in : 1'b0;
   assign sel      = reg_sel_e'(bus_addr[3:2]);

   always_comb begin
      src_eff = src_in;
      src_eff[CASCADE_SRC] = src_in[CASCADE_SRC] | casc_bit;
   end

   intc_sync_edge #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .din    (src_eff),
      .sync_q (sync_flat),
      .rise   (rise_flat)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [SRC_PER_BANK-1:0] LM = level_mask_f(VARIANT, b);
      logic hit;
      assign hit = bus_we && (bus_addr[5:4] == 2'(b));

      intc_bank #(.LMASK(LM)) u_bank (
         .clk      (clk),
         .rst      (rst),
         .wr_hit   (hit),
         .wr_sel   (sel),
         .wdata    (bus_wdata),
         .sync_in  (sync_flat[b*SRC_PER_BANK +: SRC_PER_BANK]),
         .rise     (rise_flat[b*SRC_PER_BANK +: SRC_PER_BANK]),
         .event_q  (ev_flat[b*SRC_PER_BANK +: SRC_PER_BANK]),
         .enable_q (en_flat[b*SRC_PER_BANK +: SRC_PER_BANK]),
         .pending  (pend_flat[b*SRC_PER_BANK +: SRC_PER_BANK])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr[5:4] == 2'(b)) begin
            case (sel)
               SEL_EVENT:  bus_rdata = ev_flat[b*SRC_PER_BANK +: SRC_PER_BANK];
               SEL_ENABLE: bus_rdata = en_flat[b*SRC_PER_BANK +: SRC_PER_BANK];
               SEL_LEVEL:  bus_rdata = sync_flat[b*SRC_PER_BANK +: SRC_PER_BANK];
               default:    bus_rdata = '0;
            endcase
         end
      end
   end

   intc_prio #(.WIDTH(NSRC), .IW(IDX_W)) u_prio (
      .pend (pend_flat),
      .any  (any_pend),
      .idx  (top_idx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cpu_irq    <= 1'b0;
         prio_valid <= 1'b0;
         prio_idx   <= '0;
      end else begin
         cpu_irq    <= |pend_flat;
         prio_valid <= any_pend;
         prio_idx   <= top_idx;
      end
   end

endmodule

// File: rtl/intc_edge_level_chk.sv
module intc_edge_level_chk #(
   parameter int NSRC = 64,
   parameter int IDX_W = 6,
   parameter logic [31:0] LMASK0 = 32'h3FF0_0000
) (
   input logic             clk,
   input logic             rst,
   input logic             we,
   input logic [5:0]       addr,
   input logic [31:0]      wdata,
   input logic [NSRC-1:0]  ev,
   input logic [NSRC-1:0]  en,
   input logic [NSRC-1:0]  rise,
   input logic [NSRC-1:0]  pend,
   input logic             cpu_irq,
   input logic             prio_valid,
   input logic [IDX_W-1:0] prio_idx
);

   // R2: acked bank 0 flags are clear next cycle unless a new edge arrived
   p_ack_clears_r2: assert property (@(posedge clk) disable iff (rst)
      (we && addr[5:2] == 4'h2) |=> ((ev[31:0] & $past(wdata) & ~$past(rise[31:0] & en[31:0])) == 32'h0));

   // R5: a flag only becomes set where an enabled edge was seen
   p_flag_needs_edge_r5: assert property (@(posedge clk) disable iff (rst)
      ((ev & ~$past(ev) & ~$past(rise & en)) == '0));

   // R3: level-type sources never latch
   p_level_no_latch_r3: assert property (@(posedge clk) disable iff (rst)
      ((ev[31:0] & LMASK0) == 32'h0));

   // R6: enable holds the last written word
   p_enable_readback_r6: assert property (@(posedge clk) disable iff (rst)
      (we && addr[5:2] == 4'h1) |=> (en[31:0] == $past(wdata)));

   // R8: reported index is the top set bit of last cycle's pending set
   p_prio_highest_r8: assert property (@(posedge clk) disable iff (rst)
      prio_valid |-> (($past(pend) >> prio_idx) == NSRC'(1)));

   // R7: no request while nothing was pending
   p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !cpu_irq |-> ($past(pend) == '0));

endmodule

bind intc_edge_level intc_edge_level_chk #(.NSRC(NSRC), .IDX_W(IDX_W), .LMASK0(LMASK0)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .we         (bus_we),
   .addr       (bus_addr),
   .wdata      (bus_wdata),
   .ev         (ev_flat),
   .en         (en_flat),
   .rise       (rise_flat),
   .pend       (pend_flat),
   .cpu_irq    (cpu_irq),
   .prio_valid (prio_valid),
   .prio_idx   (prio_idx)
);

// File: tb/intc_edge_level_test.sv
module intc_edge_level_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [63:0] src = '0;
   logic        casc = 1'b0;

   logic [31:0] rdata_w, rdata_n;
   logic        irq_w, irq_n, pv_w, pv_n;
   logic [5:0]  idx_w;
   logic [4:0]  idx_n;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   intc_edge_level #(.NUM_BANKS(2), .VARIANT(0)) uut (
      .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_w), .src_in(src), .casc_in(casc),
      .cpu_irq(irq_w), .prio_valid(pv_w), .prio_idx(idx_w));

   intc_edge_level #(.NUM_BANKS(1), .VARIANT(1)) uut_nar (
      .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_n), .src_in(src[31:0]), .casc_in(casc),
      .cpu_irq(irq_n), .prio_valid(pv_n), .prio_idx(idx_n));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_w(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = rdata_w;
   endtask

   task automatic rd_n(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = rdata_n;
   endtask

   task automatic setsrc(input int i, input logic v);
      @(negedge clk);
      src[i] = v;
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 cpu_irq", irq_w, 0);
      check("R1 prio_valid", pv_w, 0);
      rd_w(6'h04, d); check("R1 enable0", d, 0);
      rd_w(6'h00, d); check("R1 event0", d, 0);
      rd_w(6'h14, d); check("R1 enable1", d, 0);
   endtask

   task automatic t_readback();
      logic [31:0] d;
      wr(6'h04, 32'hA5A5_0F0F);
      rd_w(6'h04, d); check("R6 enable readback", d, 32'hA5A5_0F0F);
      rd_w(6'h08, d); check("R6 ack reads zero", d, 0);
      wr(6'h04, 32'h0);
      rd_w(6'h04, d); check("R6 enable cleared", d, 0);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      wr(6'h04, 32'h8);
      setsrc(3, 1'b1); settle(6);
      rd_w(6'h00, d); check("R4 event set", d, 32'h8);
      check("R7 irq on edge", irq_w, 1);
      check("R8 prio 3", {pv_w, idx_w}, {1'b1, 6'd3});
      setsrc(3, 1'b0); settle(6);
      rd_w(6'h00, d); check("R4 event held", d, 32'h8);
      rd_w(6'h0C, d); check("R6 level shows low", d, 0);
      wr(6'h08, 32'h0);
      rd_w(6'h00, d); check("R2 zero ack keeps", d, 32'h8);
      wr(6'h08, 32'h8); settle(2);
      rd_w(6'h00, d); check("R2 ack clears", d, 0);
      check("R7 irq drops", irq_w, 0);
      wr(6'h04, 32'h0);
   endtask

   task automatic t_ack_sel();
      logic [31:0] d;
      wr(6'h04, 32'h6);
      setsrc(1, 1'b1); setsrc(2, 1'b1); settle(6);
      setsrc(1, 1'b0); setsrc(2, 1'b0); settle(4);
      rd_w(6'h00, d); check("R2 both latched", d, 32'h6);
      wr(6'h08, 32'h2);
      rd_w(6'h00, d); check("R2 selective ack", d, 32'h4);
      wr(6'h08, 32'hFFFF_FFFF); settle(2);
      rd_w(6'h00, d); check("R2 full ack", d, 0);
      wr(6'h04, 32'h0);
   endtask

   task automatic t_already_high();
      logic [31:0] d;
      setsrc(5, 1'b1); settle(6);
      rd_w(6'h00, d); check("R5 disabled no latch", d, 0);
      wr(6'h04, 32'h20); settle(6);
      rd_w(6'h00, d); check("R5 enable while high", d, 0);
      check("R5 no request", irq_w, 0);
      setsrc(5, 1'b0); settle(4);
      setsrc(5, 1'b1); settle(6);
      rd_w(6'h00, d); check("R5 fresh edge", d, 32'h20);
      check("R5 request after edge", irq_w, 1);
      setsrc(5, 1'b0);
      wr(6'h08, 32'h20); wr(6'h04, 32'h0); settle(2);
   endtask

   task automatic t_level();
      logic [31:0] d;
      wr(6'h04, 32'h0040_0000);
      settle(2);
      @(negedge clk); src[22] = 1'b1;
      settle(2); check("R7 irq not yet after two edges", irq_w, 0);
      settle(1); check("R7 irq on third edge", irq_w, 1);
      check("R8 prio 22", {pv_w, idx_w}, {1'b1, 6'd22});
      rd_w(6'h00, d); check("R3 level no event", d, 0);
      rd_w(6'h0C, d); check("R6 level reg", d, 32'h0040_0000);
      setsrc(22, 1'b0); settle(4);
      check("R3 level drops without ack", irq_w, 0);
      wr(6'h04, 32'h0);
   endtask

   task automatic t_variant();
      logic [31:0] d;
      wr(6'h04, 32'h2000_0000);
      setsrc(29, 1'b1); settle(6);
      rd_w(6'h00, d); check("R3 wide bit29 no event", d, 0);
      rd_n(6'h00, d); check("R3 narrow bit29 latches", d, 32'h2000_0000);
      setsrc(29, 1'b0); settle(6);
      check("R3 wide bit29 gone", irq_w, 0);
      check("R3 narrow bit29 held", irq_n, 1);
      wr(6'h08, 32'h2000_0000); wr(6'h04, 32'h0); settle(2);
      check("R3 narrow cleared", irq_n, 0);
   endtask

   task automatic pulse(input int i);
      setsrc(i, 1'b1); settle(6);
      setsrc(i, 1'b0); settle(4);
   endtask

   task automatic t_prio_banks();
      logic [31:0] d;
      wr(6'h04, 32'h0002_0004);
      wr(6'h14, 32'h0040_0100);
      pulse(2); pulse(17);
      check("R8 prio 17", {pv_w, idx_w}, {1'b1, 6'd17});
      pulse(40);
      check("R8 prio 40 bank1", {pv_w, idx_w}, {1'b1, 6'd40});
      pulse(54);
      check("R8 prio 54", {pv_w, idx_w}, {1'b1, 6'd54});
      rd_w(6'h10, d); check("R9 bank1 edge latch", d, 32'h0040_0100);
      rd_w(6'h14, d); check("R9 bank1 enable", d, 32'h0040_0100);
      rd_w(6'h00, d); check("R9 bank0 events", d, 32'h0002_0004);
      wr(6'h18, 32'hFFFF_FFFF); settle(2);
      check("R8 back to 17", {pv_w, idx_w}, {1'b1, 6'd17});
      wr(6'h08, 32'hFFFF_FFFF); settle(2);
      check("R8 none pending", pv_w, 0);
      check("R7 irq low", irq_w, 0);
      wr(6'h04, 32'h0); wr(6'h14, 32'h0);
   endtask

   task automatic t_cascade();
      logic [31:0] d;
      wr(6'h04, 32'h0100_0000);
      @(negedge clk); casc = 1'b1; settle(5);
      check("R10 cascade irq", irq_w, 1);
      check("R10 cascade prio", {pv_w, idx_w}, {1'b1, 6'd24});
      rd_w(6'h0C, d); check("R10 cascade level", d, 32'h0100_0000);
      @(negedge clk); casc = 1'b0; settle(5);
      check("R10 cascade release", irq_w, 0);
      wr(6'h04, 32'h0);
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      check("R1 irq in reset", irq_w, 0);
      @(negedge clk); rst = 1'b0;
      settle(1);
      t_reset();
      t_readback();
      t_edge();
      t_ack_sel();
      t_already_high();
      t_level();
      t_variant();
      t_prio_banks();
      t_cascade();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule